// File: doc/BRIEF.md
# External Access Lockout Fuse Controller

This block guards the bus controller against external memory accesses once a small write-once configuration register has been programmed. The register holds three enable bits. One forbids external instruction fetches, one forbids external data reads and writes, and one arms the reaction to an oscillator-failure signal. A bit can be programmed but never cleared. The register survives the synchronous reset in the same way that the fuse cells it models keep their state.

The guard watches each load of the prefetch program counter and each data request the bus controller issues. Any address at or above the `INT_LIMIT` parameter counts as external. When an access of a forbidden kind targets external space, the block raises a one-cycle reset request. The prefetch counter can run up to four bytes ahead of execution. Code in the last four bytes of internal memory can therefore load an external prefetch address and trip the guard. The register is programmed through a write port that only works in slave programming mode. A read-only view of the register is always present at the output. The data-access bit also drives a flag that inhibits memory-dump mode.

Top module: `xlock_guard`

## Requirements
- R1: `cfg_rd_data` shows the register with bit 3 = instruction-fetch lockout, bit 2 = data-access lockout and bit 0 = oscillator-fail arm. Bits 7:4 and bit 1 always read 0, even after a write that sets them.
- R2: A write is accepted when `prog_mode`=1, `cfg_wr_en`=1 and `cfg_wr_addr`=`CFG_ADDR` (default 0x1FF6). An accepted write ORs the written bits 3, 2 and 0 into the register. The new value appears on `cfg_rd_data` from the cycle after the write.
- R3: A write with `prog_mode`=0, or with any other address, leaves `cfg_rd_data` unchanged.
- R4: No write and no `rst` ever clears a bit that is set.
- R5: When bit 3 is set, `pf_load`=1 with `pf_addr` >= `INT_LIMIT` drives `rst_req` high for exactly the following cycle. Addresses `INT_LIMIT` to `INT_LIMIT`+3 trip the guard; `INT_LIMIT`-1 does not. Only the prefetch address is judged.
- R6: When bit 2 is set, `dat_req`=1 with `dat_addr` >= `INT_LIMIT` drives `rst_req` high for the following cycle. A data request to an internal address does not.
- R7: When the matching bit is clear, external fetches, external data requests and oscillator failures leave `rst_req` low.
- R8: `dump_inhibit` is 1 exactly when bit 2 of the register is set.
- R9: When bit 0 is set, a rising edge of `osc_fail` gives a one-cycle `rst_req` in the next cycle. A level that stays high gives no further pulse.
- R10: Each check uses the register value held before the current cycle's write. An access in the same cycle as the write that forbids it does not trip the guard; the same access one cycle later does.
- R11: While `rst`=1, `rst_req` is 0 in the following cycle. An unprogrammed part reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not clear the register) |
| prog_mode | input | 1 | Slave programming mode active |
| cfg_wr_en | input | 1 | Programming write strobe |
| cfg_wr_addr | input | ADDR_W | Programming write address |
| cfg_wr_data | input | 8 | Programming write data |
| cfg_rd_data | output | 8 | Read-only view of the lockout register |
| pf_load | input | 1 | Prefetch program counter is loaded this cycle |
| pf_addr | input | ADDR_W | Address loaded into the prefetch counter |
| dat_req | input | 1 | Bus controller data read or write request |
| dat_addr | input | ADDR_W | Data access address |
| osc_fail | input | 1 | Oscillator-failure indication |
| rst_req | output | 1 | One-cycle device reset request |
| dump_inhibit | output | 1 | Inhibits memory-dump mode |

## Verification
Three pairs of events can fall in the same cycle. The first is a programming write that sets a lockout bit together with the very access that bit forbids. The bench issues both in one cycle, expects no reset request, then repeats the access one cycle later and expects a pulse. The second pair is a prefetch to the first external addresses together with the boundary address just below the limit; the bench checks each side of the edge. The third pair is an oscillator-failure edge together with a tripping data access. The bench expects a single pulse in the next cycle. A reference model of the register in the scoreboard judges each of these against the register value held before the write.

// File: rtl/xlock_pkg.sv
package xlock_pkg;

    localparam int FUSE_W = 8;

    // Bit positions decoded by the bus controller and reset logic
    localparam int BIT_IFETCH_OFF = 3;
    localparam int BIT_DATA_OFF   = 2;
    localparam int BIT_OSC_WATCH  = 0;

    // Only these positions accept a one; everything else stays zero
    localparam logic [FUSE_W-1:0] WRITABLE_MASK =
        FUSE_W'((1 << BIT_IFETCH_OFF) | (1 << BIT_DATA_OFF) | (1 << BIT_OSC_WATCH));

    typedef struct packed {
        logic [3:0] rsv_hi;
        logic       ifetch_off;
        logic       data_off;
        logic       rsv_lo;
        logic       osc_watch;
    } fuse_t;

    // Access ports watched by the monitor
    localparam int PORT_IFETCH = 0;
    localparam int PORT_DATA   = 1;
    localparam int NUM_PORTS   = 2;

    typedef struct packed {
        logic ifetch;
        logic data;
        logic osc;
    } trip_t;

    // Set-only merge: a write can add enable bits, never remove one
    function automatic fuse_t fuse_merge(input fuse_t cur, input logic [FUSE_W-1:0] wdata);
        return fuse_t'(FUSE_W'(cur) | (wdata & WRITABLE_MASK));
    endfunction

    function automatic logic any_trip(input trip_t t);
        return t.ifetch | t.data | t.osc;
    endfunction

endpackage

// File: rtl/xlock_fuse_bank.sv
module xlock_fuse_bank
    import xlock_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int unsigned CFG_ADDR = 32'h1FF6
) (
    input  logic              clk,
    input  logic              prog_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FUSE_W-1:0] wr_data,
    output fuse_t             fuse
);

    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    // Nonvolatile cells: blank at power-up, untouched by the logic reset
    fuse_t fuse_q = '0;
    logic  wr_hit;

    assign wr_hit = prog_mode && wr_en && (wr_addr == CFG_A);

    always_ff @(posedge clk) begin
        if (wr_hit) begin
            fuse_q <= fuse_merge(fuse_q, wr_data);
        end
    end

    assign fuse = fuse_q;

endmodule

// File: rtl/xlock_access_mon.sv
module xlock_access_mon
    import xlock_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned INT_LIMIT = 32'h4000
) (
    input  logic [NUM_PORTS-1:0]             req,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
    input  fuse_t                            fuse,
    output logic [NUM_PORTS-1:0]             trip
);

    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(INT_LIMIT);

    logic [NUM_PORTS-1:0] is_ext;
    logic [NUM_PORTS-1:0] armed;

    assign armed[PORT_IFETCH] = fuse.ifetch_off;
    assign armed[PORT_DATA]   = fuse.data_off;

    // One external-space comparator per watched port
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign is_ext[g] = req[g] && (addr[g] >= LIMIT_A);
        assign trip[g]   = is_ext[g] && armed[g];
    end

endmodule

// File: rtl/xlock_osc_gate.sv
module xlock_osc_gate (
    input  logic clk,
    input  logic rst,
    input  logic osc_fail,
    input  logic enable,
    output logic osc_trip
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= osc_fail;
        end
    end

    // Only a fresh failure edge counts, so a stuck level asks once
    assign osc_trip = enable && osc_fail && !prev_q;

endmodule

// File: rtl/xlock_guard.sv
module xlock_guard
    import xlock_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned INT_LIMIT = 32'h4000,
    parameter int unsigned CFG_ADDR  = 32'h1FF6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_mode,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [7:0]        cfg_wr_data,
    output logic [7:0]        cfg_rd_data,
    input  logic              pf_load,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              dat_req,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic              osc_fail,
    output logic              rst_req,
    output logic              dump_inhibit
);

    fuse_t                            fuse;
    logic [NUM_PORTS-1:0]             acc_req;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] acc_addr;
    logic [NUM_PORTS-1:0]             acc_trip;
    logic                             osc_trip;
    trip_t                            trips;
    logic                             rst_req_q;

    xlock_fuse_bank #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_bank (
        .clk       (clk),
        .prog_mode (prog_mode),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .fuse      (fuse)
    );

    assign acc_req[PORT_IFETCH]  = pf_load;
    assign acc_addr[PORT_IFETCH] = pf_addr;
    assign acc_req[PORT_DATA]    = dat_req;
    assign acc_addr[PORT_DATA]   = dat_addr;

    xlock_access_mon #(
        .ADDR_W    (ADDR_W),
        .INT_LIMIT (INT_LIMIT)
    ) u_mon (
        .req  (acc_req),
        .addr (acc_addr),
        .fuse (fuse),
        .trip (acc_trip)
    );

    xlock_osc_gate u_osc (
        .clk      (clk),
        .rst      (rst),
        .osc_fail (osc_fail),
        .enable   (fuse.osc_watch),
        .osc_trip (osc_trip)
    );

    always_comb begin
        trips.ifetch = acc_trip[PORT_IFETCH];
        trips.data   = acc_trip[PORT_DATA];
        trips.osc    = osc_trip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= any_trip(trips);
        end
    end

    assign rst_req      = rst_req_q;
    assign cfg_rd_data  = 8'(fuse);
    assign dump_inhibit = fuse.data_off;

endmodule

// File: rtl/xlock_guard_chk.sv
module xlock_guard_chk #(
    parameter int          ADDR_W    = 16,
    parameter int unsigned INT_LIMIT = 32'h4000
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_mode,
    input logic              pf_load,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              dat_req,
    input logic [ADDR_W-1:0] dat_addr,
    input logic              osc_fail,
    input logic [7:0]        cfg_rd_data,
    input logic              rst_req,
    input logic              dump_inhibit
);

    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(INT_LIMIT);

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[7:4] == 4'h0) && !cfg_rd_data[1]);

    // R3
    no_wr_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_mode |=> $stable(cfg_rd_data));

    // R4
    no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(cfg_rd_data) & ~cfg_rd_data) == 8'h00));

    // R5
    ifetch_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_load && (pf_addr >= LIMIT_A) && cfg_rd_data[3]) |=> rst_req);

    // R6
    data_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_req && (dat_addr >= LIMIT_A) && cfg_rd_data[2]) |=> rst_req);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!pf_load && !dat_req && !osc_fail) |=> !rst_req);

    // R8
    inhibit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(dump_inhibit));

endmodule

bind xlock_guard xlock_guard_chk #(
    .ADDR_W    (ADDR_W),
    .INT_LIMIT (INT_LIMIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .prog_mode    (prog_mode),
    .pf_load      (pf_load),
    .pf_addr      (pf_addr),
    .dat_req      (dat_req),
    .dat_addr     (dat_addr),
    .osc_fail     (osc_fail),
    .cfg_rd_data  (cfg_rd_data),
    .rst_req      (rst_req),
    .dump_inhibit (dump_inhibit)
);

// File: tb/test_xlock_guard.sv
`timescale 1ns/1ps
module test_xlock_guard;

    localparam int          AW  = 16;
    localparam logic [15:0] LIM = 16'h4000;
    localparam logic [15:0] CFG = 16'h1FF6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_mode = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic        pf_load = 1'b0;
    logic [15:0] pf_addr = '0;
    logic        dat_req = 1'b0;
    logic [15:0] dat_addr = '0;
    logic        osc_fail = 1'b0;
    logic        rst_req;
    logic        dump_inhibit;

    always #2.5 clk = ~clk;

    xlock_guard #(.ADDR_W(AW), .INT_LIMIT(32'h4000), .CFG_ADDR(32'h1FF6)) i_xlock_guard (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .pf_load(pf_load), .pf_addr(pf_addr), .dat_req(dat_req), .dat_addr(dat_addr),
        .osc_fail(osc_fail), .rst_req(rst_req), .dump_inhibit(dump_inhibit)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Scoreboard queues: one entry per driven cycle
    int          q_cyc[$];
    logic        q_rr[$];
    logic [7:0]  q_rd[$];
    logic        q_inh[$];
    string       q_tag[$];

    // Reference model state
    logic [7:0] m_fuse = 8'h00;
    logic       m_osc_prev = 1'b0;

    task automatic step(input logic r, input logic pm, input logic we,
                        input logic [15:0] wa, input logic [7:0] wd,
                        input logic pl, input logic [15:0] pa,
                        input logic dr, input logic [15:0] da,
                        input logic of, input string tag);
        logic trip;
        @(negedge clk);
        rst = r; prog_mode = pm; cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd;
        pf_load = pl; pf_addr = pa; dat_req = dr; dat_addr = da; osc_fail = of;
        trip = (pl && pa >= LIM && m_fuse[3]) ||
               (dr && da >= LIM && m_fuse[2]) ||
               (of && !m_osc_prev && m_fuse[0]);
        if (r) trip = 1'b0;
        if (pm && we && wa == CFG) m_fuse = m_fuse | (wd & 8'h0D);
        m_osc_prev = r ? 1'b0 : of;
        q_cyc.push_back(cyc + 1);
        q_rr.push_back(trip);
        q_rd.push_back(m_fuse);
        q_inh.push_back(m_fuse[2]);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic prog(input logic [7:0] wd, input string tag);
        step(1'b0, 1'b1, 1'b1, CFG, wd, 1'b0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic fetch(input logic [15:0] pa, input string tag);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, pa, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic data(input logic [15:0] da, input string tag);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1, da, 1'b0, tag);
    endtask

    task automatic osc(input logic of, input string tag);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, of, tag);
    endtask

    // Monitor: compare results that were due in this cycle
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            if (q_cyc[0] == cyc) begin
                checks++;
                if (rst_req !== q_rr[0]) begin
                    fails++;
                    $display("FAIL %s rst_req actual=%b expected=%b (cycle %0d)", q_tag[0], rst_req, q_rr[0], cyc);
                end
                checks++;
                if (cfg_rd_data !== q_rd[0]) begin
                    fails++;
                    $display("FAIL %s cfg_rd_data actual=%h expected=%h (cycle %0d)", q_tag[0], cfg_rd_data, q_rd[0], cyc);
                end
                checks++;
                if (dump_inhibit !== q_inh[0]) begin
                    fails++;
                    $display("FAIL %s dump_inhibit actual=%b expected=%b (cycle %0d)", q_tag[0], dump_inhibit, q_inh[0], cyc);
                end
            end
            void'(q_cyc.pop_front());
            void'(q_rr.pop_front());
            void'(q_rd.pop_front());
            void'(q_inh.pop_front());
            void'(q_tag.pop_front());
        end
    end

    initial begin
        // R11 reset state
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R11");
        idle("R11");

        // R7 blank part: nothing trips
        fetch(16'hFFFF, "R7");
        data(16'h8000, "R7");
        osc(1'b1, "R7");
        osc(1'b0, "R7");

        // R3 ignored writes
        step(1'b0, 1'b0, 1'b1, CFG, 8'hFF, 1'b0, '0, 1'b0, '0, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b1, 16'h1FF7, 8'hFF, 1'b0, '0, 1'b0, '0, 1'b0, "R3");

        // R1 reserved bits never stick
        prog(8'hF2, "R1");

        // R10 same-cycle write and forbidden fetch; R2 write accepted
        step(1'b0, 1'b1, 1'b1, CFG, 8'h08, 1'b1, LIM, 1'b0, '0, 1'b0, "R10");
        fetch(LIM, "R10");

        // R5 boundary and prefetch-ahead window
        fetch(LIM - 16'd1, "R5");
        fetch(LIM, "R5");
        fetch(LIM + 16'd3, "R5");
        idle("R5");
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 16'hF000, 1'b0, '0, 1'b0, "R5");

        // R7 data lockout still clear
        data(16'hFFFF, "R7");

        // R2 and R8 data lockout programmed
        prog(8'h04, "R8");
        data(LIM - 16'd1, "R6");
        data(16'hFFFF, "R6");
        data(LIM, "R6");

        // R4 zero write and reset keep bits
        prog(8'h00, "R4");
        step(1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b0, '0, '0, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0, "R11");
        idle("R4");

        // R9 oscillator gating
        osc(1'b1, "R7");
        osc(1'b0, "R9");
        prog(8'h01, "R2");
        osc(1'b1, "R9");
        osc(1'b1, "R9");
        osc(1'b0, "R9");
        osc(1'b1, "R9");
        osc(1'b0, "R9");

        // R9 osc edge together with a tripping data access: one pulse
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1, 16'h9000, 1'b1, "R9");
        idle("R9");

        // R1 all-ones write keeps reserved bits at zero
        prog(8'hFF, "R1");
        idle("R1");
        idle("R1");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule